// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-to-physical page translations for a processor core. It keeps two arrays of the same shape, one for instruction fetches and one for data accesses. A lookup presents a logical address together with the privilege level, the access kind and the read or write direction. A hit returns the cached physical page and its attribute bits one cycle later. A hit also reports any fault that the stored attributes imply for this access.

On a miss the block raises a walk request to an external page-table walker and holds its stall output high. When the walker answers with a descriptor, the block writes an entry under one of two fill policies. The permissive policy stores every walk result, including failed and bus-errored walks, as a zero-attribute entry. The strict policy stores only resident descriptors and reports a failure straight away. After the fill the block retries the lookup and answers. A probe request always walks, even on a hit, fills an entry and returns the page with its attributes packed in one word. A flush input invalidates both arrays at once.

Top module: `xlat_cache`

## Requirements
- R1: The tag holds the privilege level together with the page number. An entry filled by a supervisor access does not hit for a user access to the same address, which starts a new walk.
- R2: With 4 KiB pages the set index is address bits [15:12] and every page bit takes part in the tag. With 8 KiB pages (`page_8k`=1) the set index is bits [16:13], bit 12 is ignored in tag matching, and bit 12 of the returned page reads as 0.
- R3: Instruction accesses (`req_data`=0) and data accesses (`req_data`=1) use separate arrays. A fill made for one kind never hits for the other.
- R4: A fill replaces the way that already holds the same tag if there is one, otherwise the lowest invalid way, otherwise the way chosen by a free-running counter. A set therefore holds as many tags as it has ways, and one tag more evicts one of them.
- R5: A hit is answered in the cycle after acceptance. It sets `resp_valid` and `resp_hit` and starts no walk. `resp_word` is {page[31:12], 0, attr[10:0]}, where attr keeps descriptor bits 0 (resident), 2 (write-protect), 4 (modified), 6:5 (cache mode), 7 (supervisor-only), 9:8 (user attributes) and 10 (global), and every other bit is zero.
- R6: On a miss, `stall` and `walk_req` rise in the cycle after acceptance and stay high until the walker's done pulse. `walk_addr` holds steady while they are high. The answer arrives one cycle after the fill.
- R7: Fault bits are PF=bit0, SV=bit1, WP=bit2 and BE=bit3. A hit on a non-resident entry sets PF. A supervisor-only entry used in user mode sets SV. A write to a write-protected entry sets WP. Each condition is judged on its own.
- R8: Under the permissive policy (`fill_strict`=0), a walk that returns a non-resident descriptor creates an entry with zero page and zero attributes. Later lookups of that page hit without a walk and report PF.
- R9: Under the strict policy (`fill_strict`=1), a non-resident descriptor creates no entry. The answer has `resp_hit`=0 and PF set, and the next lookup walks again.
- R10: A bus error on the walk sets BE in the answer. Under the permissive policy it also leaves a zero entry, so later lookups hit with PF only. Under the strict policy no entry is made.
- R11: A probe always walks, even on a hit. The walk is a write when `req_op_rw`=0 and a read when it is 1. The answer sets `resp_probe`, clears `resp_hit` and all fault bits, and returns the filled word: 0x800 after a bus error, 0 after a non-resident descriptor.
- R12: A one-cycle `flush` invalidates every entry in both arrays. A fill that completes in the same cycle as the flush survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_8k | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB |
| fill_strict | input | 1 | 1 caches resident walks only |
| flush | input | 1 | Invalidate both arrays |
| req_valid | input | 1 | Request strobe, taken while stall is low |
| req_addr | input | 32 | Logical address |
| req_super | input | 1 | Supervisor privilege |
| req_data | input | 1 | 1 data access, 0 instruction fetch |
| req_write | input | 1 | Write access (lookups) |
| req_probe | input | 1 | Request is a probe |
| req_op_rw | input | 1 | Probe direction bit, 0 means write |
| stall | output | 1 | Busy with a walk or retry |
| walk_req | output | 1 | Walk request level |
| walk_addr | output | 32 | Address to walk |
| walk_super | output | 1 | Privilege of the walk |
| walk_write | output | 1 | Direction of the walk |
| walk_done | input | 1 | Walker result strobe |
| walk_desc | input | 32 | Page descriptor from the walker |
| walk_berr | input | 1 | Bus error during the walk |
| resp_valid | output | 1 | Answer strobe |
| resp_probe | output | 1 | Answer belongs to a probe |
| resp_hit | output | 1 | Lookup found an entry |
| resp_word | output | 32 | Page and attributes |
| resp_fault | output | 4 | Fault bits PF, SV, WP, BE |

## Verification
A flush and a fill can fall in the same cycle, with the flush clearing every valid bit while the fill sets one. The bench raises the flush exactly in the cycle that its walker model returns a descriptor. It then checks that the freshly filled page hits without a walk while a page cached earlier needs a new walk. A randomized run mixes both policies, both privilege levels, both arrays and probes over a small page pool, so that hits, misses and evictions alternate.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
   localparam int VA_W  = 32;
   localparam int PPN_W = VA_W - 12;
   localparam int ST_W  = 11;
   localparam int TAG_W = PPN_W + 1;

   localparam int ST_RES = 0;
   localparam int ST_WP  = 2;
   localparam int ST_SUP = 7;
   localparam logic [ST_W-1:0] ST_KEEP = 11'h7F5;
   localparam int WORD_BERR = 11;

   localparam int FLT_W  = 4;
   localparam int FLT_PF = 0;
   localparam int FLT_SV = 1;
   localparam int FLT_WP = 2;
   localparam int FLT_BE = 3;

   typedef enum logic [1:0] {XS_IDLE, XS_WALK, XS_RETRY} xs_state_e;
endpackage

// File: rtl/xlat_way_array.sv
module xlat_way_array
   import xlat_cache_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [IDX_W-1:0] lk_idx_i,
   input  logic [TAG_W-1:0] lk_tag_i,
   input  logic             lk_big_i,
   output logic [WAYS-1:0]  hit_vec_o,
   output logic [WAYS-1:0]  vld_vec_o,
   output logic [PPN_W-1:0] hit_ppn_o,
   output logic [ST_W-1:0]  hit_st_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [WAY_W-1:0] wr_way_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [PPN_W-1:0] wr_ppn_i,
   input  logic [ST_W-1:0]  wr_st_i
);
   logic [WAYS-1:0]  vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [PPN_W-1:0] ppn_q [SETS][WAYS];
   logic [ST_W-1:0]  st_q  [SETS][WAYS];
   logic [TAG_W-1:0] cmp_mask;

   // tag bit 0 is address bit 12, a page-offset bit with 8 KiB pages
   assign cmp_mask = lk_big_i ? ~TAG_W'(1) : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (flush_i) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
         end
         if (wr_en_i) vld_q[wr_idx_i][wr_way_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
         ppn_q[wr_idx_i][wr_way_i] <= wr_ppn_i;
         st_q[wr_idx_i][wr_way_i]  <= wr_st_i;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      logic match;
      assign match        = ((tag_q[lk_idx_i][w] ^ lk_tag_i) & cmp_mask) == '0;
      assign vld_vec_o[w] = vld_q[lk_idx_i][w];
      assign hit_vec_o[w] = vld_q[lk_idx_i][w] & match & ~flush_i;
   end

   always_comb begin
      hit_ppn_o = '0;
      hit_st_o  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec_o[w]) begin
            hit_ppn_o = hit_ppn_o | ppn_q[lk_idx_i][w];
            hit_st_o  = hit_st_o  | st_q[lk_idx_i][w];
         end
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]  hit_vec_i,
   input  logic [WAYS-1:0]  vld_vec_i,
   input  logic [WAY_W-1:0] rnd_i,
   output logic [WAY_W-1:0] way_o
);
   logic [WAY_W-1:0] hit_way, free_way;

   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec_i[w])  hit_way  = WAY_W'(w);
         if (!vld_vec_i[w]) free_way = WAY_W'(w);
      end
      if (|hit_vec_i)       way_o = hit_way;
      else if (!(&vld_vec_i)) way_o = free_way;
      else                  way_o = rnd_i;
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_cache_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        page_8k,
   input  logic        fill_strict,
   input  logic        flush,
   input  logic        req_valid,
   input  logic [31:0] req_addr,
   input  logic        req_super,
   input  logic        req_data,
   input  logic        req_write,
   input  logic        req_probe,
   input  logic        req_op_rw,
   output logic        stall,
   output logic        walk_req,
   output logic [31:0] walk_addr,
   output logic        walk_super,
   output logic        walk_write,
   input  logic        walk_done,
   input  logic [31:0] walk_desc,
   input  logic        walk_berr,
   output logic        resp_valid,
   output logic        resp_probe,
   output logic        resp_hit,
   output logic [31:0] resp_word,
   output logic [3:0]  resp_fault
);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (13 + IDX_W > VA_W) begin : g_bad_idx
      $error("set index runs past the address");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("WAYS must be at least 1");
   end

   xs_state_e        state_q;
   logic [31:0]      c_addr;
   logic             c_super, c_data, c_write, c_probe;
   logic [FLT_W-1:0] c_wflt;
   logic [WAY_W-1:0] rnd_q;

   logic             idle;
   logic [PPN_W-1:0] lk_vpn;
   logic             lk_super, lk_data, lk_write, eff_write;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] lk_idx;

   logic [WAYS-1:0]  hv [2];
   logic [WAYS-1:0]  vv [2];
   logic [PPN_W-1:0] hp [2];
   logic [ST_W-1:0]  hs [2];
   logic [WAYS-1:0]  hv_sel, vv_sel;
   logic [PPN_W-1:0] ppn_sel;
   logic [ST_W-1:0]  st_sel;
   logic             hit_any;
   logic [FLT_W-1:0] hit_flt;
   logic [31:0]      hit_word;

   logic [31:0]      fill_word;
   logic             fill_good, fill_en;
   logic [PPN_W-1:0] fill_ppn;
   logic [ST_W-1:0]  fill_st;
   logic [FLT_W-1:0] walk_flt;
   logic [31:0]      probe_word;
   logic [WAY_W-1:0] victim;

   // ---------------- lookup path ----------------
   assign idle      = (state_q == XS_IDLE);
   assign eff_write = req_probe ? ~req_op_rw : req_write;
   assign lk_vpn    = idle ? req_addr[31:12] : c_addr[31:12];
   assign lk_super  = idle ? req_super : c_super;
   assign lk_data   = idle ? req_data  : c_data;
   assign lk_write  = idle ? eff_write : c_write;
   assign lk_tag    = {lk_super, lk_vpn};
   assign lk_idx    = page_8k ? lk_vpn[1 +: IDX_W] : lk_vpn[0 +: IDX_W];

   for (genvar side = 0; side < 2; side++) begin : g_side
      xlat_way_array #(.SETS(SETS), .WAYS(WAYS)) u_arr (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush_i   (flush),
         .lk_idx_i  (lk_idx),
         .lk_tag_i  (lk_tag),
         .lk_big_i  (page_8k),
         .hit_vec_o (hv[side]),
         .vld_vec_o (vv[side]),
         .hit_ppn_o (hp[side]),
         .hit_st_o  (hs[side]),
         .wr_en_i   (fill_en && (c_data == 1'(side))),
         .wr_idx_i  (lk_idx),
         .wr_way_i  (victim),
         .wr_tag_i  (lk_tag),
         .wr_ppn_i  (fill_ppn),
         .wr_st_i   (fill_st)
      );
   end

   assign hv_sel  = hv[lk_data];
   assign vv_sel  = vv[lk_data];
   assign ppn_sel = hp[lk_data];
   assign st_sel  = hs[lk_data];
   assign hit_any = |hv_sel;
   assign hit_word = {ppn_sel, 1'b0, st_sel};

   always_comb begin
      hit_flt         = '0;
      hit_flt[FLT_PF] = ~st_sel[ST_RES];
      hit_flt[FLT_SV] = st_sel[ST_SUP] & ~lk_super;
      hit_flt[FLT_WP] = st_sel[ST_WP] & lk_write;
   end

   // ---------------- fill path ----------------
   xlat_victim #(.WAYS(WAYS)) u_victim (
      .hit_vec_i (hv_sel),
      .vld_vec_i (vv_sel),
      .rnd_i     (rnd_q),
      .way_o     (victim)
   );

   assign fill_word = walk_desc & {{PPN_W{1'b1}}, 1'b0, ST_KEEP};
   assign fill_good = fill_word[ST_RES] & ~walk_berr;
   assign fill_en   = (state_q == XS_WALK) && walk_done && (!fill_strict || fill_good);
   assign fill_ppn  = fill_good ? (fill_word[31:12] & ~PPN_W'(page_8k)) : '0;
   assign fill_st   = fill_good ? fill_word[ST_W-1:0] : '0;

   always_comb begin
      walk_flt = '0;
      if (walk_berr)               walk_flt[FLT_BE] = 1'b1;
      else if (!walk_desc[ST_RES]) walk_flt[FLT_PF] = 1'b1;
      if (walk_berr)      probe_word = 32'(1) << WORD_BERR;
      else if (fill_good) probe_word = {fill_ppn, 1'b0, fill_st};
      else                probe_word = '0;
   end

   // ---------------- control ----------------
   assign stall      = !idle;
   assign walk_req   = (state_q == XS_WALK);
   assign walk_addr  = c_addr;
   assign walk_super = c_super;
   assign walk_write = c_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= '0;
      end else begin
         rnd_q <= (rnd_q == WAY_W'(WAYS - 1)) ? '0 : rnd_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= XS_IDLE;
         c_addr     <= '0;
         c_super    <= 1'b0;
         c_data     <= 1'b0;
         c_write    <= 1'b0;
         c_probe    <= 1'b0;
         c_wflt     <= '0;
         resp_valid <= 1'b0;
         resp_probe <= 1'b0;
         resp_hit   <= 1'b0;
         resp_word  <= '0;
         resp_fault <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            XS_IDLE: begin
               if (req_valid) begin
                  c_addr  <= req_addr;
                  c_super <= req_super;
                  c_data  <= req_data;
                  c_write <= eff_write;
                  c_probe <= req_probe;
                  c_wflt  <= '0;
                  if (!req_probe && hit_any) begin
                     resp_valid <= 1'b1;
                     resp_probe <= 1'b0;
                     resp_hit   <= 1'b1;
                     resp_word  <= hit_word;
                     resp_fault <= hit_flt;
                  end else begin
                     state_q <= XS_WALK;
                  end
               end
            end
            XS_WALK: begin
               if (walk_done) begin
                  if (c_probe) begin
                     resp_valid <= 1'b1;
                     resp_probe <= 1'b1;
                     resp_hit   <= 1'b0;
                     resp_word  <= probe_word;
                     resp_fault <= '0;
                     state_q    <= XS_IDLE;
                  end else begin
                     c_wflt  <= walk_flt;
                     state_q <= XS_RETRY;
                  end
               end
            end
            XS_RETRY: begin
               resp_valid <= 1'b1;
               resp_probe <= 1'b0;
               resp_hit   <= hit_any;
               resp_word  <= hit_any ? hit_word : '0;
               resp_fault <= c_wflt | (hit_any ? hit_flt : '0);
               state_q    <= XS_IDLE;
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stall,
   input logic       walk_req,
   input logic       walk_done,
   input logic [31:0] walk_addr,
   input logic       resp_valid,
   input logic       resp_probe,
   input logic       resp_hit,
   input logic       resp_res,
   input logic [3:0] resp_fault
);
   AST_WALK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> stall);                                                   // R6
   AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req && !walk_done |=> walk_req && $stable(walk_addr));            // R6
   AST_ANSWER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !stall);                                                // R6
   AST_NONRES_PF: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_hit && !resp_res |-> resp_fault[0]);                // R7
   AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_probe |-> resp_fault == 4'b0000 && !resp_hit);      // R11
endmodule

bind xlat_cache xlat_cache_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stall      (stall),
   .walk_req   (walk_req),
   .walk_done  (walk_done),
   .walk_addr  (walk_addr),
   .resp_valid (resp_valid),
   .resp_probe (resp_probe),
   .resp_hit   (resp_hit),
   .resp_res   (resp_word[0]),
   .resp_fault (resp_fault)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
   logic clk = 0, rst_n = 0;
   logic page_8k = 0, fill_strict = 0, flush_tb = 0, flush_wk = 0, flush;
   logic req_valid = 0, req_super = 0, req_data = 0, req_write = 0, req_probe = 0, req_op_rw = 1;
   logic [31:0] req_addr = 0;
   logic stall, walk_req, walk_super, walk_write;
   logic [31:0] walk_addr;
   logic walk_done = 0, walk_berr = 0;
   logic [31:0] walk_desc = 0;
   logic resp_valid, resp_probe, resp_hit;
   logic [31:0] resp_word;
   logic [3:0] resp_fault;

   int tests = 0, fails = 0, walks = 0, wcnt = 0;
   bit finished = 0;
   logic ov_en = 0, ov_berr = 0, flush_at_done = 0, last_wr = 0;
   logic [31:0] ov_desc = 0;
   // results of the last access
   int lat, nwalk;
   logic r_hit, r_probe, r_stall;
   logic [31:0] r_word;
   logic [3:0] r_flt;

   assign flush = flush_tb | flush_wk;
   always #10 clk = ~clk;

   xlat_cache u_dut (.clk(clk), .rst_n(rst_n), .page_8k(page_8k), .fill_strict(fill_strict),
      .flush(flush), .req_valid(req_valid), .req_addr(req_addr), .req_super(req_super),
      .req_data(req_data), .req_write(req_write), .req_probe(req_probe), .req_op_rw(req_op_rw),
      .stall(stall), .walk_req(walk_req), .walk_addr(walk_addr), .walk_super(walk_super),
      .walk_write(walk_write), .walk_done(walk_done), .walk_desc(walk_desc), .walk_berr(walk_berr),
      .resp_valid(resp_valid), .resp_probe(resp_probe), .resp_hit(resp_hit),
      .resp_word(resp_word), .resp_fault(resp_fault));

   function automatic logic [31:0] desc_fn(input logic [31:0] a, input logic sup);
      logic [31:0] h;
      h = (32'(a[31:13]) * 32'h9E3779B1) ^ (sup ? 32'h7F4A7C15 : 32'h0);
      return {h[31:12], h[11:1], (h[15:13] != 3'b000)};
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] d, input logic big);
      if (!d[0]) return 32'h0;
      return {d[31:13], d[12] & ~big, 1'b0, d[10:0] & 11'h7F5};
   endfunction

   function automatic logic [3:0] exp_flt(input logic [31:0] d, input logic sup, input logic wr);
      if (!d[0]) return 4'b0001;
      return {1'b0, d[2] & wr, d[7] & ~sup, 1'b0};
   endfunction

   // walker model: answers two cycles after the request appears
   always @(negedge clk) begin
      if (walk_req && !walk_done) begin
         wcnt++;
         if (wcnt == 2) begin
            wcnt = 0;
            walk_done = 1;
            walk_berr = ov_berr;
            walk_desc = ov_en ? ov_desc : desc_fn(walk_addr, walk_super);
            last_wr   = walk_write;
            flush_wk  = flush_at_done;
            walks++;
         end
      end else begin
         walk_done = 0;
         walk_berr = 0;
         flush_wk  = 0;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   task automatic access(input logic [31:0] a, input logic sup, input logic dat,
                         input logic wr, input logic prb, input logic oprw);
      int w0;
      @(negedge clk);
      w0 = walks;
      req_addr = a; req_super = sup; req_data = dat; req_write = wr;
      req_probe = prb; req_op_rw = oprw; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      r_stall = stall;
      while (!resp_valid && lat < 50) begin
         @(negedge clk);
         lat++;
      end
      r_hit = resp_hit; r_probe = resp_probe; r_word = resp_word; r_flt = resp_fault;
      nwalk = walks - w0;
   endtask

   task automatic do_flush();
      @(negedge clk); flush_tb = 1;
      @(negedge clk); flush_tb = 0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [31:0] a, d;
      int tot;
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // reset state
      chk(!stall && !walk_req && !resp_valid, "R6 reset outputs idle", {stall, walk_req, resp_valid}, 0);
      rst_n = 1;

      a = 32'h0040_3000;
      d = desc_fn(a, 1);
      access(a, 1, 1, 0, 0, 1);
      chk(lat == 4, "R6 miss latency", lat, 4);
      chk(r_stall == 1, "R6 stall during walk", r_stall, 1);
      chk(nwalk == 1 && r_hit, "R6 one walk then retry hit", nwalk, 1);
      chk(r_word == exp_word(d, 0), "R5 word after fill", r_word, exp_word(d, 0));
      access(a, 1, 1, 0, 0, 1);
      chk(lat == 1 && nwalk == 0 && r_hit, "R5 hit one cycle no walk", lat, 1);
      chk(r_word == exp_word(d, 0), "R5 hit word", r_word, exp_word(d, 0));
      chk(r_flt == exp_flt(d, 1, 0), "R7 hit fault", r_flt, exp_flt(d, 1, 0));
      access(a, 0, 1, 0, 0, 1);
      chk(nwalk == 1, "R1 user misses supervisor entry", nwalk, 1);
      access(a, 1, 0, 0, 0, 1);
      chk(nwalk == 1, "R3 instruction array separate", nwalk, 1);
      access(a ^ 32'h1000, 1, 1, 0, 0, 1);
      chk(nwalk == 1, "R2 bit12 in tag with 4K", nwalk, 1);

      // 4K: five tags in one set evict
      do_flush();
      for (int k = 0; k < 5; k++) access(32'h0100_5000 + k * 32'h10000, 1, 1, 0, 0, 1);
      tot = 0;
      for (int k = 0; k < 5; k++) begin access(32'h0100_5000 + k * 32'h10000, 1, 1, 0, 0, 1); tot += nwalk; end
      chk(tot >= 1, "R4 extra tag evicts in full set", tot, 1);
      // 4K: bits 15:12 spread over sets
      do_flush();
      for (int k = 0; k < 5; k++) access(32'h0100_5000 + k * 32'h1000, 1, 1, 0, 0, 1);
      tot = 0;
      for (int k = 0; k < 5; k++) begin access(32'h0100_5000 + k * 32'h1000, 1, 1, 0, 0, 1); tot += nwalk; end
      chk(tot == 0, "R2 4K index bits 15:12", tot, 0);
      // invalid ways first, then a fifth tag lands
      do_flush();
      for (int k = 0; k < 4; k++) access(32'h0300_2000 + k * 32'h10000, 0, 1, 0, 0, 1);
      tot = 0;
      for (int k = 0; k < 4; k++) begin access(32'h0300_2000 + k * 32'h10000, 0, 1, 0, 0, 1); tot += nwalk; end
      chk(tot == 0, "R4 fills use invalid ways", tot, 0);
      access(32'h0304_2000, 0, 1, 0, 0, 1);
      access(32'h0304_2000, 0, 1, 0, 0, 1);
      chk(nwalk == 0 && r_hit, "R4 fifth tag cached", nwalk, 0);

      // 8K pages
      do_flush();
      page_8k = 1;
      a = 32'h0050_6000;
      d = desc_fn(a, 1);
      access(a, 1, 1, 0, 0, 1);
      access(a ^ 32'h1000, 1, 1, 0, 0, 1);
      chk(nwalk == 0 && r_hit, "R2 8K ignores bit12", nwalk, 0);
      chk(r_word == exp_word(d, 1), "R2 8K page word", r_word, exp_word(d, 1));
      do_flush();
      for (int k = 0; k < 5; k++) access(32'h0100_4000 + k * 32'h10000, 1, 1, 0, 0, 1);
      tot = 0;
      for (int k = 0; k < 5; k++) begin access(32'h0100_4000 + k * 32'h10000, 1, 1, 0, 0, 1); tot += nwalk; end
      chk(tot == 0, "R2 8K index bits 16:13", tot, 0);
      do_flush();
      page_8k = 0;

      // attribute faults
      ov_en = 1;
      ov_desc = 32'h1234_5081;
      access(32'h0200_0000, 0, 1, 0, 0, 1);
      chk(r_flt == 4'b0010 && r_hit, "R7 supervisor violation", r_flt, 4'b0010);
      chk(r_word == 32'h1234_5081, "R5 stored attributes", r_word, 32'h1234_5081);
      ov_desc = 32'h2222_2005;
      access(32'h0210_0000, 0, 1, 1, 0, 1);
      chk(r_flt == 4'b0100, "R7 write protect", r_flt, 4'b0100);
      access(32'h0210_0000, 0, 1, 0, 0, 1);
      chk(r_flt == 4'b0000 && nwalk == 0, "R7 read of protected page", r_flt, 0);

      // permissive policy, failed walk
      ov_desc = 32'h3333_3000;
      access(32'h0220_0000, 1, 1, 0, 0, 1);
      chk(r_hit && r_word == 0 && r_flt == 4'b0001, "R8 zero entry PF", r_flt, 4'b0001);
      access(32'h0220_0000, 1, 1, 0, 0, 1);
      chk(nwalk == 0 && r_hit && r_flt == 4'b0001, "R8 resident fault entry", nwalk, 0);
      // strict policy
      fill_strict = 1;
      access(32'h0230_0000, 1, 1, 0, 0, 1);
      chk(!r_hit && r_flt == 4'b0001 && r_word == 0, "R9 strict fault no entry", r_flt, 4'b0001);
      access(32'h0230_0000, 1, 1, 0, 0, 1);
      chk(nwalk == 1, "R9 strict walks again", nwalk, 1);
      // bus errors
      ov_berr = 1;
      access(32'h0240_0000, 1, 1, 0, 0, 1);
      chk(!r_hit && r_flt == 4'b1000, "R10 strict bus error", r_flt, 4'b1000);
      access(32'h0240_0000, 1, 1, 0, 0, 1);
      chk(nwalk == 1, "R10 strict bus error no entry", nwalk, 1);
      fill_strict = 0;
      access(32'h0250_0000, 1, 1, 0, 0, 1);
      chk(r_hit && r_flt == 4'b1001, "R10 permissive bus error", r_flt, 4'b1001);
      ov_berr = 0;
      access(32'h0250_0000, 1, 1, 0, 0, 1);
      chk(nwalk == 0 && r_flt == 4'b0001, "R10 bus error entry kept", r_flt, 4'b0001);

      // probes
      ov_en = 0;
      a = 32'h0060_1000;
      d = desc_fn(a, 1);
      access(a, 1, 1, 0, 0, 1);
      access(a, 1, 1, 0, 1, 0);
      chk(nwalk == 1 && r_probe && !r_hit, "R11 probe walks on hit", nwalk, 1);
      chk(last_wr == 1, "R11 op bit clear is write", last_wr, 1);
      chk(r_word == exp_word(d, 0) && r_flt == 0, "R11 probe word", r_word, exp_word(d, 0));
      access(a, 1, 1, 0, 1, 1);
      chk(last_wr == 0, "R11 op bit set is read", last_wr, 0);
      ov_berr = 1;
      access(32'h0610_0000, 1, 1, 0, 1, 1);
      chk(r_word == 32'h800, "R11 probe bus error word", r_word, 32'h800);
      ov_berr = 0; ov_en = 1; ov_desc = 32'h3333_3000;
      access(32'h0620_0000, 1, 1, 0, 1, 1);
      chk(r_word == 0 && r_probe, "R11 probe failed walk word", r_word, 0);
      ov_en = 0;

      // flush
      access(a, 1, 1, 0, 0, 1);
      do_flush();
      access(a, 1, 1, 0, 0, 1);
      chk(nwalk == 1, "R12 flush invalidates", nwalk, 1);
      flush_at_done = 1;
      access(32'h0700_3000, 1, 0, 0, 0, 1);
      flush_at_done = 0;
      access(32'h0700_3000, 1, 0, 0, 0, 1);
      chk(nwalk == 0 && r_hit, "R12 fill survives same-cycle flush", nwalk, 0);
      access(a, 1, 1, 0, 0, 1);
      chk(nwalk == 1, "R12 same-cycle flush clears others", nwalk, 1);

      // randomized mix
      do_flush();
      for (int i = 0; i < 300; i++) begin
         logic sup, dat, wr, prb;
         if (i % 50 == 0) fill_strict = $urandom % 2;
         a   = (($urandom % 6) << 12) | (($urandom % 8) << 16) | 32'h0800_0000;
         sup = $urandom % 2; dat = $urandom % 2; wr = $urandom % 2; prb = ($urandom % 8) == 0;
         d = desc_fn(a, sup);
         access(a, sup, dat, wr, prb, ~wr);
         chk(r_word == exp_word(d, 0), "R5 random word", r_word, exp_word(d, 0));
         if (prb) chk(r_flt == 0 && r_probe, "R11 random probe", r_flt, 0);
         else     chk(r_flt == exp_flt(d, sup, wr), "R7 random fault", r_flt, exp_flt(d, sup, wr));
      end

      finished = 1;
      summary();
   end
endmodule